// File: doc/BRIEF.md
# Protection System Register File

This block holds the processor state that governs memory protection. It has a 32-bit control word whose bit 0 selects real mode (0) or protected mode (1), two 48-bit table-pointer registers for the global and interrupt descriptor tables, and two selector registers for the local descriptor table and the task register. Each selector register also has a hidden cache that stores the base and limit of the referenced descriptor. An upstream decoder issues one request per cycle. The request carries an operation code, a 48-bit data word, and, for selector loads, the descriptor base and limit that the requester has already fetched. One cycle later the block returns a response. The response carries read data or a fault.

Selector loads and stores are refused in real mode with an undefined-opcode indication (vector 6). A selector load in protected mode is also checked. A null index, or a selector that points at a local table, is refused with a protection fault, and nothing is written. The machine-status-word write can raise the mode bit but cannot lower it. Only a full control-word write can return the processor to real mode. The cached bases and limits are driven out continuously so that address logic can use them.

Top module: `prot_sysreg_file`

## Requirements
- R1: After reset: control word = 0 (real mode), both table pointers = base 0 with limit 0xFFFF, both selectors = 0, both caches = 0, no response pending.
- R2: Op code 1 (status-word write) replaces control-word bits 3:1 with data bits 3:1 and ORs data bit 0 into bit 0. Bits 31:4 are kept, and the mode bit is never cleared by this op.
- R3: Op code 2 writes all 32 control-word bits from data bits 31:0, which can clear the mode bit. Op code 3 returns the control word.
- R4: Op codes 4 and 6 load the global and interrupt table pointers from the 48-bit data (base in 47:16, limit in 15:0). Op codes 5 and 7 return them in the same layout.
- R5: In protected mode, op code 8 (local table) or op code 10 (task register) with an acceptable selector in data bits 15:0 stores the selector. The same edge stores desc_base/desc_limit into that register's cache. Op codes 9 and 11 return the selector.
- R6: With the mode bit 0, op codes 8, 9, 10 and 11 respond with rsp_ud=1 and read data 0, and change no selector or cache.
- R7: A selector load whose bits 15:3 are all zero, or whose bit 2 is set, responds with rsp_gp=1 and leaves the selector and cache unchanged.
- R8: Every request with req_valid=1 produces rsp_valid=1 on the next cycle, and no response appears otherwise. Read data is zero-extended, and writes and op code 0 return 0.
- R9: Op codes 12 to 15 respond with rsp_ud=1 and change no register.
- R10: rsp_ud and rsp_gp are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 4 | Operation code |
| req_data | input | 48 | Write data or selector |
| desc_base | input | 32 | Descriptor base for selector loads |
| desc_limit | input | 20 | Descriptor limit for selector loads |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 48 | Read data |
| rsp_ud | output | 1 | Undefined-opcode fault (vector 6) |
| rsp_gp | output | 1 | Selector protection fault |
| pe | output | 1 | Protected mode active |
| ldt_base | output | 32 | Local table cached base |
| ldt_limit | output | 20 | Local table cached limit |
| tr_base | output | 32 | Task register cached base |
| tr_limit | output | 20 | Task register cached limit |

## Verification
The hardest case to reach is the mode bit surviving a status-word write that tries to clear it, followed by a return to real mode through a full control-word write with stale selector caches still in place. A selector access issued right after that must trap and leave the caches untouched. Directed sequences walk through that order explicitly. The random phase then picks op codes uniformly and data bit 0 at random, so the mode toggles often. Selectors are biased toward the null and table-indicator cases so that both fault paths are hit in both modes.

// File: rtl/prot_pkg.sv
// Package: operation codes and selector checks shared by the protection
// register file and its checker. Assumes a 16-bit selector with the
// table-indicator at bit 2 and a two-bit privilege field below it.
package prot_pkg;

    typedef enum logic [3:0] {
        OP_NOP    = 4'd0,
        OP_LMSW   = 4'd1,
        OP_CR0_WR = 4'd2,
        OP_CR0_RD = 4'd3,
        OP_GDT_LD = 4'd4,
        OP_GDT_ST = 4'd5,
        OP_IDT_LD = 4'd6,
        OP_IDT_ST = 4'd7,
        OP_LDT_LD = 4'd8,
        OP_LDT_ST = 4'd9,
        OP_TSK_LD = 4'd10,
        OP_TSK_ST = 4'd11
    } sysop_e;

    localparam int SEL_W  = 16;
    localparam int TI_BIT = 2;

    // A selector is acceptable when it indexes a non-null global entry.
    function automatic logic sel_ok(input logic [SEL_W-1:0] sel);
        return (sel[SEL_W-1:TI_BIT+1] != '0) && !sel[TI_BIT];
    endfunction

endpackage

// File: rtl/prot_cr0_reg.sv
// Control word register. A full write replaces every bit; the status-word
// write touches only the low MSW_BITS bits and can set, never clear, bit 0.
// Assumes the two write enables are never asserted together.
module prot_cr0_reg #(
    parameter int CR_W     = 32,
    parameter int MSW_BITS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            full_en,
    input  logic            msw_en,
    input  logic [CR_W-1:0] wr_data,
    output logic [CR_W-1:0] cr_q
);

    // Hold or update the control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr_q <= '0;
        end else if (full_en) begin
            cr_q <= wr_data;
        end else if (msw_en) begin
            cr_q <= {cr_q[CR_W-1:MSW_BITS], wr_data[MSW_BITS-1:1],
                     wr_data[0] | cr_q[0]};
        end
    end

endmodule

// File: rtl/prot_dtable_reg.sv
// Descriptor-table pointer: base in the upper bits, limit in the lower bits.
// Resets to base zero and an all-ones limit.
module prot_dtable_reg #(
    parameter int BASE_W = 32,
    parameter int LIM_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld_en,
    input  logic [BASE_W+LIM_W-1:0] ld_data,
    output logic [BASE_W+LIM_W-1:0] ptr_q
);

    localparam logic [BASE_W+LIM_W-1:0] RST_VAL = {{BASE_W{1'b0}}, {LIM_W{1'b1}}};

    // Hold or load the table pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)     ptr_q <= RST_VAL;
        else if (ld_en) ptr_q <= ld_data;
    end

endmodule

// File: rtl/prot_sel_reg.sv
// Selector register with a hidden descriptor cache. The visible selector
// and the cached base/limit are written together on one load. The caller
// has already validated the selector and the mode.
module prot_sel_reg #(
    parameter int SEL_W  = 16,
    parameter int BASE_W = 32,
    parameter int CLIM_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic [BASE_W-1:0] base_in,
    input  logic [CLIM_W-1:0] lim_in,
    output logic [SEL_W-1:0]  sel_q,
    output logic [BASE_W-1:0] base_q,
    output logic [CLIM_W-1:0] lim_q
);

    // Refresh selector and cache on a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            base_q <= '0;
            lim_q  <= '0;
        end else if (ld_en) begin
            sel_q  <= sel_in;
            base_q <= base_in;
            lim_q  <= lim_in;
        end
    end

endmodule

// File: rtl/prot_sysreg_file.sv
// Protection register file top. It decodes one request per cycle, gates
// selector access on the mode bit, validates selector loads, and registers
// a response one cycle later. Assumes the requester supplies descriptor
// contents with each selector load.
module prot_sysreg_file
    import prot_pkg::*;
#(
    parameter int CR_W   = 32,
    parameter int BASE_W = 32,
    parameter int LIM_W  = 16,
    parameter int CLIM_W = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [3:0]              req_op,
    input  logic [BASE_W+LIM_W-1:0] req_data,
    input  logic [BASE_W-1:0]       desc_base,
    input  logic [CLIM_W-1:0]       desc_limit,
    output logic                    rsp_valid,
    output logic [BASE_W+LIM_W-1:0] rsp_data,
    output logic                    rsp_ud,
    output logic                    rsp_gp,
    output logic                    pe,
    output logic [BASE_W-1:0]       ldt_base,
    output logic [CLIM_W-1:0]       ldt_limit,
    output logic [BASE_W-1:0]       tr_base,
    output logic [CLIM_W-1:0]       tr_limit
);

    localparam int DATA_W = BASE_W + LIM_W;
    localparam int NSEL   = 2;   // index 0: local table, 1: task register

    logic [CR_W-1:0]   cr0_q;
    logic [DATA_W-1:0] gdtr_q, idtr_q;
    logic [SEL_W-1:0]  sel_q  [NSEL];
    logic [BASE_W-1:0] cbase_q[NSEL];
    logic [CLIM_W-1:0] clim_q [NSEL];
    logic [SEL_W-1:0]  ldt_sel_q, tr_sel_q;

    logic              cr_full_en, cr_msw_en, gdt_ld, idt_ld;
    logic [NSEL-1:0]   sel_ld;
    logic              op_ud, op_gp;
    logic [DATA_W-1:0] rd_val;

    assign pe = cr0_q[0];

    // Decode the request into write enables, read data and faults.
    always_comb begin
        cr_full_en = 1'b0;
        cr_msw_en  = 1'b0;
        gdt_ld     = 1'b0;
        idt_ld     = 1'b0;
        sel_ld     = '0;
        op_ud      = 1'b0;
        op_gp      = 1'b0;
        rd_val     = '0;
        if (req_valid) begin
            case (req_op)
                OP_NOP:    ;
                OP_LMSW:   cr_msw_en  = 1'b1;
                OP_CR0_WR: cr_full_en = 1'b1;
                OP_CR0_RD: rd_val     = DATA_W'(cr0_q);
                OP_GDT_LD: gdt_ld     = 1'b1;
                OP_GDT_ST: rd_val     = gdtr_q;
                OP_IDT_LD: idt_ld     = 1'b1;
                OP_IDT_ST: rd_val     = idtr_q;
                OP_LDT_LD, OP_TSK_LD: begin
                    if (!pe)                            op_ud = 1'b1;
                    else if (!sel_ok(req_data[SEL_W-1:0])) op_gp = 1'b1;
                    else if (req_op == OP_LDT_LD)       sel_ld[0] = 1'b1;
                    else                                sel_ld[1] = 1'b1;
                end
                OP_LDT_ST: begin
                    if (!pe) op_ud  = 1'b1;
                    else     rd_val = DATA_W'(sel_q[0]);
                end
                OP_TSK_ST: begin
                    if (!pe) op_ud  = 1'b1;
                    else     rd_val = DATA_W'(sel_q[1]);
                end
                default:   op_ud = 1'b1;
            endcase
        end
    end

    prot_cr0_reg #(.CR_W(CR_W), .MSW_BITS(4)) u_cr0 (
        .clk(clk), .rst_n(rst_n), .full_en(cr_full_en), .msw_en(cr_msw_en),
        .wr_data(req_data[CR_W-1:0]), .cr_q(cr0_q)
    );

    prot_dtable_reg #(.BASE_W(BASE_W), .LIM_W(LIM_W)) u_gdtr (
        .clk(clk), .rst_n(rst_n), .ld_en(gdt_ld), .ld_data(req_data), .ptr_q(gdtr_q)
    );

    prot_dtable_reg #(.BASE_W(BASE_W), .LIM_W(LIM_W)) u_idtr (
        .clk(clk), .rst_n(rst_n), .ld_en(idt_ld), .ld_data(req_data), .ptr_q(idtr_q)
    );

    for (genvar g = 0; g < NSEL; g++) begin : g_sel
        prot_sel_reg #(.SEL_W(SEL_W), .BASE_W(BASE_W), .CLIM_W(CLIM_W)) u_sel (
            .clk(clk), .rst_n(rst_n), .ld_en(sel_ld[g]),
            .sel_in(req_data[SEL_W-1:0]), .base_in(desc_base), .lim_in(desc_limit),
            .sel_q(sel_q[g]), .base_q(cbase_q[g]), .lim_q(clim_q[g])
        );
    end

    assign ldt_sel_q = sel_q[0];
    assign tr_sel_q  = sel_q[1];
    assign ldt_base  = cbase_q[0];
    assign ldt_limit = clim_q[0];
    assign tr_base   = cbase_q[1];
    assign tr_limit  = clim_q[1];

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_ud    <= 1'b0;
            rsp_gp    <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_data  <= rd_val;
            rsp_ud    <= op_ud;
            rsp_gp    <= op_gp;
        end
    end

endmodule

// File: rtl/prot_sysreg_chk.sv
// Checker for the protection register file: response timing, mode-bit
// stickiness, real-mode trapping and fault exclusivity.
module prot_sysreg_chk
    import prot_pkg::*;
#(
    parameter int DATA_W = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [3:0]        req_op,
    input logic [DATA_W-1:0] req_data,
    input logic              rsp_valid,
    input logic              rsp_ud,
    input logic              rsp_gp,
    input logic              pe,
    input logic [SEL_W-1:0]  ldt_sel_q,
    input logic [SEL_W-1:0]  tr_sel_q
);

    AST_MSW_KEEPS_PE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_LMSW && pe) |=> pe); // R2

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R8

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R8

    AST_REAL_MODE_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !pe && req_op >= OP_LDT_LD && req_op <= OP_TSK_ST) |=> rsp_ud); // R6

    AST_REAL_MODE_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !pe) |=> ($stable(ldt_sel_q) && $stable(tr_sel_q))); // R6

    AST_BAD_SEL_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pe && (req_op == OP_LDT_LD || req_op == OP_TSK_LD)
         && !sel_ok(req_data[SEL_W-1:0])) |=> (rsp_gp && $stable(ldt_sel_q) && $stable(tr_sel_q))); // R7

    AST_UNDEF_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op > OP_TSK_ST) |=> rsp_ud); // R9

    AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_ud && rsp_gp)); // R10

endmodule

bind prot_sysreg_file prot_sysreg_chk #(.DATA_W(BASE_W + LIM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_data(req_data), .rsp_valid(rsp_valid), .rsp_ud(rsp_ud), .rsp_gp(rsp_gp),
    .pe(pe), .ldt_sel_q(ldt_sel_q), .tr_sel_q(tr_sel_q)
);

// File: tb/sim_prot_sysreg_file.sv
`timescale 1ns/1ps
module sim_prot_sysreg_file;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_op = '0;
    logic [47:0] req_data = '0;
    logic [31:0] desc_base = '0;
    logic [19:0] desc_limit = '0;
    logic        rsp_valid, rsp_ud, rsp_gp, pe;
    logic [47:0] rsp_data;
    logic [31:0] ldt_base, tr_base;
    logic [19:0] ldt_limit, tr_limit;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    prot_sysreg_file u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_data(req_data), .desc_base(desc_base), .desc_limit(desc_limit),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ud(rsp_ud), .rsp_gp(rsp_gp),
        .pe(pe), .ldt_base(ldt_base), .ldt_limit(ldt_limit),
        .tr_base(tr_base), .tr_limit(tr_limit)
    );

    // Bench model of architectural state.
    logic [31:0] m_cr0;
    logic [47:0] m_gdt, m_idt;
    logic [15:0] m_sel  [2];
    logic [31:0] m_base [2];
    logic [19:0] m_lim  [2];

    function automatic logic [31:0] f_msw(input logic [31:0] old, input logic [47:0] d);
        return {old[31:4], d[3:1], d[0] | old[0]};
    endfunction

    function automatic logic f_sel_good(input logic [15:0] s);
        return (s[15:3] != 13'd0) && !s[2];
    endfunction

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cr0 = '0; m_gdt = 48'h0000_0000_FFFF; m_idt = 48'h0000_0000_FFFF;
        for (int i = 0; i < 2; i++) begin m_sel[i] = '0; m_base[i] = '0; m_lim[i] = '0; end
    endtask

    // Apply one request at a falling edge, check response at the next one.
    task automatic apply(input string req, input int op, input logic [47:0] d,
                         input logic [31:0] db, input logic [19:0] dl);
        logic [47:0] e_data;
        logic        e_ud, e_gp;
        int          k;
        e_data = '0; e_ud = 1'b0; e_gp = 1'b0;
        k = (op == 10 || op == 11) ? 1 : 0;
        case (op)
            1:  m_cr0 = f_msw(m_cr0, d);
            2:  m_cr0 = d[31:0];
            3:  e_data = {16'd0, m_cr0};
            4:  m_gdt = d;
            5:  e_data = m_gdt;
            6:  m_idt = d;
            7:  e_data = m_idt;
            8, 10: begin
                if (!m_cr0[0]) e_ud = 1'b1;
                else if (!f_sel_good(d[15:0])) e_gp = 1'b1;
                else begin m_sel[k] = d[15:0]; m_base[k] = db; m_lim[k] = dl; end
            end
            9, 11: begin
                if (!m_cr0[0]) e_ud = 1'b1;
                else e_data = {32'd0, m_sel[k]};
            end
            0:  ;
            default: e_ud = 1'b1;
        endcase
        req_valid = 1'b1; req_op = 4'(op); req_data = d; desc_base = db; desc_limit = dl;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " rsp_valid"}, 48'(rsp_valid), 48'd1);
        check({req, " rsp_data"}, rsp_data, e_data);
        check({req, " rsp_ud"}, 48'(rsp_ud), 48'(e_ud));
        check({req, " rsp_gp"}, 48'(rsp_gp), 48'(e_gp));
        check({req, " pe"}, 48'(pe), 48'(m_cr0[0]));
        check({req, " ldt cache"}, {ldt_limit[15:0], ldt_base}, {m_lim[0][15:0], m_base[0]});
        check({req, " tr cache"}, {tr_limit[15:0], tr_base}, {m_lim[1][15:0], m_base[1]});
        check({req, " cache hi"}, 48'({ldt_limit[19:16], tr_limit[19:16]}),
              48'({m_lim[0][19:16], m_lim[1][19:16]}));
    endtask

    function automatic logic [15:0] rand_sel();
        int pick = $urandom_range(0, 3);
        logic [15:0] s = 16'($urandom);
        if (pick == 0) s[15:3] = '0;
        else if (pick == 1) s[2] = 1'b1;
        else begin s[2] = 1'b0; if (s[15:3] == '0) s[3] = 1'b1; end
        return s;
    endfunction

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check("R1 rsp_valid", 48'(rsp_valid), 48'd0);
        check("R1 pe", 48'(pe), 48'd0);
        check("R1 ldt cache", {ldt_limit[15:0], ldt_base}, 48'd0);
        check("R1 tr cache", {tr_limit[15:0], tr_base}, 48'd0);
        apply("R1 cr0 read", 3, '0, '0, '0);
        apply("R1 gdtr read", 5, '0, '0, '0);
        apply("R1 idtr read", 7, '0, '0, '0);
        // R6: real-mode trap on every selector op
        apply("R6 lldt real", 8, 48'h0008, 32'hDEAD_BEEF, 20'hABCDE);
        apply("R6 sldt real", 9, '0, '0, '0);
        apply("R6 ltr real", 10, 48'h0010, 32'h1111_2222, 20'h33333);
        apply("R6 str real", 11, '0, '0, '0);
        // R2: status-word write sets PE, keeps high bits
        apply("R3 cr0 write", 2, 48'h0000_8000_0000, '0, '0);
        apply("R2 msw set pe", 1, 48'hFFFF_FFFF_FFF1, '0, '0);
        apply("R2 cr0 read", 3, '0, '0, '0);
        apply("R1 sldt after reset", 9, '0, '0, '0);
        apply("R2 msw clear try", 1, 48'h0000_0000_000E, '0, '0);
        apply("R2 cr0 read", 3, '0, '0, '0);
        // R4: table pointers
        apply("R4 lgdt", 4, 48'h1234_5678_9ABC, '0, '0);
        apply("R4 lidt", 6, 48'hFEDC_BA98_0123, '0, '0);
        apply("R4 sgdt", 5, '0, '0, '0);
        apply("R4 sidt", 7, '0, '0, '0);
        // R5: selector loads fill caches
        apply("R5 lldt", 8, 48'h0000_0000_0018, 32'hCAFE_0000, 20'hF00F1);
        apply("R5 ltr", 10, 48'h0000_0000_002B, 32'h0BAD_F00D, 20'h00067);
        apply("R5 sldt", 9, '0, '0, '0);
        apply("R5 str", 11, '0, '0, '0);
        // R7: null and local-table selectors fault
        apply("R7 lldt null", 8, 48'h0003, 32'h1, 20'h1);
        apply("R7 ltr ti", 10, 48'h0024, 32'h2, 20'h2);
        apply("R7 sldt after", 9, '0, '0, '0);
        // R9: undefined op codes
        apply("R9 op12", 12, 48'hFFFF_FFFF_FFFF, '1, '1);
        apply("R9 op15", 15, 48'hFFFF_FFFF_FFFF, '1, '1);
        // R3: full write clears PE, then selector ops trap again with caches kept
        apply("R3 cr0 clear pe", 2, 48'h0000_0000_0000, '0, '0);
        apply("R6 ltr after exit", 10, 48'h0030, 32'h5, 20'h5);
        apply("R8 nop", 0, 48'h1, '0, '0);
        // R8: idle cycle gives no response
        @(negedge clk);
        check("R8 idle", 48'(rsp_valid), 48'd0);
        // R10 and random mix
        for (int i = 0; i < 3000; i++) begin
            int op = $urandom_range(0, 15);
            logic [47:0] d = {16'($urandom), 32'($urandom)};
            if (op == 8 || op == 10) d = {32'd0, rand_sel()};
            apply("R10 random", op, d, 32'($urandom), 20'($urandom));
            check("R10 exclusive", 48'(rsp_ud & rsp_gp), 48'd0);
        end
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule